// File: doc/BRIEF.md
# Infrared Pulse-Distance Frame Transmitter

This block turns a small game packet into the on/off level stream an infrared emitter needs, one sample at a time. A packet has a 3-bit type, an 8-bit sender identifier and a 5-bit value. When a start strobe is accepted the block captures the packet and computes an 8-bit CRC over the 16 data bits. It then plays out the frame: a long header mark, a short header gap, and 24 pulse-distance coded bits. In each bit the length of the quiet interval ahead of a fixed-length mark carries the bit value.

The output advances only on cycles where the sample-enable input is high, so one enable pulse is one output sample. The block can sit on any clock faster than the sample rate. A busy flag covers the whole frame, and a one-cycle done pulse marks its end. A build parameter complements the level for emitters driven active-low. Carrier modulation and drive strength are handled elsewhere.

Top module: `irpd_tx`

## Requirements
- R1: After reset, the level output is inactive, busy is low and done is low.
- R2: A start request while idle is accepted at that clock edge. Busy is high from the next cycle. The level stays unchanged until the first sample-enable cycle after acceptance.
- R3: Every frame opens with 32 active samples followed by 8 inactive samples.
- R4: Each coded bit is an inactive space and then 8 active samples. The space is 8 samples for a 0 and 16 samples for a 1.
- R5: The 24 frame bits go out LSB-first. Frame bits [2:0] hold the type, [10:3] the identifier, [15:11] the value and [23:16] the CRC.
- R6: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00. It covers frame byte [7:0] and then byte [15:8], most significant bit first within each byte, and is computed by the block itself.
- R7: The level and the frame position move only on clock edges where sample-enable is high. Each such edge emits exactly one sample.
- R8: On the sample-enable cycle after the last mark sample, the level returns to inactive, busy falls and done is high for exactly one clock cycle.
- R9: A start request while busy is ignored. The frame in progress completes unchanged.
- R10: With the inversion parameter set, the level output is the complement of the non-inverted output, idle included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample-rate enable; one pulse per output sample |
| start | input | 1 | Request to load and send a packet |
| pkt_type | input | 3 | Packet type field |
| pkt_id | input | 8 | Sender identifier field |
| pkt_val | input | 5 | Value field |
| level_o | output | 1 | Emitter level (polarity set by parameter) |
| busy_o | output | 1 | High while a frame is loaded or being sent |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Busy is due one clock after an accepted start. Each sample's level is due just after the rising edge of the clock cycle in which sample-enable is high. Done and the fall of busy come on the first enable edge after the last mark sample. The bench builds the full expected sample list for each packet from the coding rules and its own CRC. It drives sample-enable from its own pattern, including gaps of idle clocks, and reads the outputs on the falling edge after each enable edge. It also checks on every non-enable cycle that the level has not moved.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HMARK = 3'd1,
    PH_HGAP  = 3'd2,
    PH_SPACE = 3'd3,
    PH_MARK  = 3'd4,
    PH_END   = 3'd5
  } irpd_phase_e;

  function automatic int irpd_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/irpd_rst_sync.sv
module irpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/irpd_crc.sv
module irpd_crc #(
  parameter int          DATA_W = 16,
  parameter int          CRC_W  = 8,
  parameter logic [7:0]  POLY   = 8'h07
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  localparam int NBYTES = DATA_W / 8;

  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = 0; i < NBYTES; i++) begin
      for (int b = 7; b >= 0; b--) begin
        fb = c[CRC_W-1] ^ data_i[i*8+b];
        c  = {c[CRC_W-2:0], 1'b0};
        if (fb) c = c ^ POLY[CRC_W-1:0];
      end
    end
    crc_o = c;
  end

endmodule

// File: rtl/irpd_seq.sv
module irpd_seq
  import irpd_pkg::*;
#(
  parameter int FRAME_W  = 24,
  parameter int HDR_MARK = 32,
  parameter int HDR_GAP  = 8,
  parameter int MARK_LEN = 8,
  parameter int SPACE0   = 8,
  parameter int SPACE1   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               emit_o,
  output logic               act_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam int MAXL   = irpd_max4(HDR_MARK, HDR_GAP, MARK_LEN, SPACE1 > SPACE0 ? SPACE1 : SPACE0);
  localparam int CNT_W  = $clog2(MAXL + 1);
  localparam int BIDX_W = $clog2(FRAME_W);

  localparam logic [CNT_W-1:0]  HM_LAST = CNT_W'(HDR_MARK - 1);
  localparam logic [CNT_W-1:0]  HG_LAST = CNT_W'(HDR_GAP - 1);
  localparam logic [CNT_W-1:0]  MK_LAST = CNT_W'(MARK_LEN - 1);
  localparam logic [CNT_W-1:0]  S0_LAST = CNT_W'(SPACE0 - 1);
  localparam logic [CNT_W-1:0]  S1_LAST = CNT_W'(SPACE1 - 1);
  localparam logic [BIDX_W-1:0] B_LAST  = BIDX_W'(FRAME_W - 1);

  irpd_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BIDX_W-1:0]  bidx_q, bidx_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               done_q, done_d;
  logic [CNT_W-1:0]   sp_last;

  assign sp_last = sh_q[0] ? S1_LAST : S0_LAST;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    bidx_d  = bidx_q;
    sh_d    = sh_q;
    done_d  = 1'b0;
    act_o   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_HMARK;
          cnt_d   = '0;
          bidx_d  = '0;
          sh_d    = frame_i;
        end
      end
      PH_HMARK: begin
        act_o = 1'b1;
        if (smp_en) begin
          if (cnt_q == HM_LAST) begin
            phase_d = PH_HGAP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_HGAP: begin
        if (smp_en) begin
          if (cnt_q == HG_LAST) begin
            phase_d = PH_SPACE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_SPACE: begin
        if (smp_en) begin
          if (cnt_q == sp_last) begin
            phase_d = PH_MARK;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_MARK: begin
        act_o = 1'b1;
        if (smp_en) begin
          if (cnt_q == MK_LAST) begin
            cnt_d = '0;
            sh_d  = {1'b0, sh_q[FRAME_W-1:1]};
            if (bidx_q == B_LAST) begin
              phase_d = PH_END;
            end else begin
              bidx_d  = bidx_q + 1'b1;
              phase_d = PH_SPACE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_END: begin
        if (smp_en) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      sh_q    <= sh_d;
      done_q  <= done_d;
    end
  end

  assign emit_o = smp_en && (phase_q != PH_IDLE);
  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/irpd_drv.sv
module irpd_drv #(
  parameter bit INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic emit_i,
  input  logic act_i,
  output logic level_o
);

  logic act_q, act_d;

  always_comb act_d = emit_i ? act_i : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  generate
    if (INVERT) begin : g_active_low
      assign level_o = ~act_q;
    end else begin : g_active_high
      assign level_o = act_q;
    end
  endgenerate

endmodule

// File: rtl/irpd_tx.sv
module irpd_tx #(
  parameter int         TYPE_W   = 3,
  parameter int         ID_W     = 8,
  parameter int         VAL_W    = 5,
  parameter int         CRC_W    = 8,
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter int         HDR_MARK = 32,
  parameter int         HDR_GAP  = 8,
  parameter int         MARK_LEN = 8,
  parameter int         SPACE0   = 8,
  parameter int         SPACE1   = 16,
  parameter bit         INVERT   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              start,
  input  logic [TYPE_W-1:0] pkt_type,
  input  logic [ID_W-1:0]   pkt_id,
  input  logic [VAL_W-1:0]  pkt_val,
  output logic              level_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int DATA_W  = TYPE_W + ID_W + VAL_W;
  localparam int FRAME_W = DATA_W + CRC_W;

  logic               rst_int_n;
  logic [DATA_W-1:0]  data_w;
  logic [CRC_W-1:0]   crc_w;
  logic [FRAME_W-1:0] frame_w;
  logic               emit_w;
  logic               act_w;

  irpd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign data_w  = {pkt_val, pkt_id, pkt_type};

  irpd_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .data_i (data_w),
    .crc_o  (crc_w)
  );

  assign frame_w = {crc_w, data_w};

  irpd_seq #(
    .FRAME_W  (FRAME_W),
    .HDR_MARK (HDR_MARK),
    .HDR_GAP  (HDR_GAP),
    .MARK_LEN (MARK_LEN),
    .SPACE0   (SPACE0),
    .SPACE1   (SPACE1)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .smp_en  (smp_en),
    .start   (start),
    .frame_i (frame_w),
    .emit_o  (emit_w),
    .act_o   (act_w),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  irpd_drv #(.INVERT(INVERT)) u_drv (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .emit_i  (emit_w),
    .act_i   (act_w),
    .level_o (level_o)
  );

endmodule

// File: rtl/irpd_tx_chk.sv
module irpd_tx_chk #(
  parameter bit INVERT = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic smp_en,
  input logic start,
  input logic level_o,
  input logic busy_o,
  input logic done_o
);

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o) |=> busy_o);  // R2

  AST_START_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o) |=> $stable(level_o));  // R2

  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(level_o));  // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !smp_en) |=> busy_o);  // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);  // R8

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (level_o == INVERT));  // R10

endmodule

bind irpd_tx irpd_tx_chk #(.INVERT(INVERT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_en  (smp_en),
  .start   (start),
  .level_o (level_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/irpd_tx_test.sv
module irpd_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0;
  logic       start = 1'b0;
  logic [2:0] pkt_type = '0;
  logic [7:0] pkt_id = '0;
  logic [4:0] pkt_val = '0;
  logic       level, busy, done;
  logic       level_n, busy_n, done_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic exp_s [0:1023];
  int   exp_n;

  always #2 clk = ~clk;

  irpd_tx uut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .start(start),
    .pkt_type(pkt_type), .pkt_id(pkt_id), .pkt_val(pkt_val),
    .level_o(level), .busy_o(busy), .done_o(done)
  );

  irpd_tx #(.INVERT(1'b1)) uut_inv (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .start(start),
    .pkt_type(pkt_type), .pkt_id(pkt_id), .pkt_val(pkt_val),
    .level_o(level_n), .busy_o(busy_n), .done_o(done_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] c;
    c = 8'h00;
    c = c ^ b0;
    repeat (8) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    c = c ^ b1;
    repeat (8) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  task automatic build(input logic [2:0] t, input logic [7:0] id, input logic [4:0] v);
    logic [15:0] d;
    logic [23:0] f;
    int k;
    d = {v, id, t};
    f = {ref_crc(d[7:0], d[15:8]), d};
    k = 0;
    for (int i = 0; i < 32; i++) begin exp_s[k] = 1'b1; k++; end
    for (int i = 0; i < 8; i++)  begin exp_s[k] = 1'b0; k++; end
    for (int i = 0; i < 24; i++) begin
      for (int j = 0; j < (f[i] ? 16 : 8); j++) begin exp_s[k] = 1'b0; k++; end
      for (int j = 0; j < 8; j++) begin exp_s[k] = 1'b1; k++; end
    end
    exp_n = k;
  endtask

  task automatic run_frame(input logic [2:0] t, input logic [7:0] id, input logic [4:0] v,
                           input int period, input bit interfere);
    int mism, inv_bad, stat_bad, moved;
    logic prev;
    build(t, id, v);
    @(negedge clk);
    pkt_type = t; pkt_id = id; pkt_val = v;
    start = 1'b1; smp_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", busy, 1);
    chk(level == 1'b0, "R2", level, 0);
    mism = 0; inv_bad = 0; stat_bad = 0; moved = 0;
    for (int k = 0; k <= exp_n; k++) begin
      for (int w = 0; w < period - 1; w++) begin
        prev = level;
        @(negedge clk);
        if (level != prev) moved++;
        if (!busy) stat_bad++;
      end
      smp_en = 1'b1;
      if (interfere && k == 100) begin
        start = 1'b1;
        pkt_type = ~t; pkt_id = ~id; pkt_val = ~v;
      end
      @(negedge clk);
      smp_en = 1'b0;
      start = 1'b0;
      if (k < exp_n) begin
        if (level != exp_s[k]) mism++;
        if (level_n != ~level) inv_bad++;
        if (done || !busy) stat_bad++;
      end else begin
        chk(level == 1'b0, "R8", level, 0);
        chk(done == 1'b1, "R8", done, 1);
        chk(busy == 1'b0, "R8", busy, 0);
        chk(level_n == 1'b1, "R10", level_n, 1);
      end
    end
    if (interfere) chk(mism == 0, "R9", mism, 0);
    else           chk(mism == 0, "R3 R4 R5 R6", mism, 0);
    chk(inv_bad == 0, "R10", inv_bad, 0);
    chk(stat_bad == 0, "R8", stat_bad, 0);
    if (period > 1) chk(moved == 0, "R7", moved, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle outputs after reset
    chk(level == 1'b0, "R1", level, 0);
    chk(level_n == 1'b1, "R1", level_n, 1);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(done == 1'b0, "R1", done, 0);
    // R7: ticks while idle do not move the level
    smp_en = 1'b1;
    repeat (5) @(negedge clk);
    smp_en = 1'b0;
    chk(level == 1'b0 && !busy, "R7", level, 0);

    // R5: every type value, fixed id and value
    for (int t = 0; t < 8; t++) run_frame(3'(t), 8'hA5, 5'd19, 1, 1'b0);
    // R5: walking one across the identifier
    for (int j = 0; j < 8; j++) run_frame(3'd0, 8'(1 << j), 5'd0, 1, 1'b0);
    // R6: every value with varied identifiers
    for (int v = 0; v < 32; v++) run_frame(3'(v), 8'(v * 37 + 11), 5'(v), 1, 1'b0);
    // R4: extreme bit patterns
    run_frame(3'h0, 8'h00, 5'h00, 1, 1'b0);
    run_frame(3'h7, 8'hFF, 5'h1F, 1, 1'b0);
    // R7: sparse sample-enable
    run_frame(3'd1, 8'd42, 5'd23, 3, 1'b0);
    run_frame(3'd6, 8'h3C, 5'd9, 4, 1'b0);
    // R9: start while busy
    run_frame(3'd2, 8'h81, 5'd5, 1, 1'b1);
    run_frame(3'd5, 8'h18, 5'd30, 2, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule